// File: doc/BRIEF.md
# UART Receive Buffer with Flags

This block is the receive-side character buffer of a serial port. Each stored entry is a received byte together with four condition bits above it: framing error, parity error, break and overrun. Entries come either from the line receiver or, when internal loopback is selected, from the transmit side. A loopback break request stores a break entry: break bit set and zero data. Software takes entries out through a data-register read strobe. The oldest entry is shown combinationally on `pop_data_o` during the read cycle.

A mode input picks one of two depths while running. When it is high the buffer is 16 entries deep. When it is low it is a single holding register of depth 1. Every change of the mode input flushes the buffer. The block drives empty and full flags and a ready output back to the writer. It also raises a receive interrupt with trigger-level hysteresis. On every read strobe, the condition bits of the entry read are copied into a status register. A clear strobe sets that register to zero.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset `empty_o`=1, `full_o`=0, `rx_irq_o`=0, `status_o`=0 and `push_ready_o`=1.
- R2: With `fifo_en_i`=1 the buffer holds 16 entries and returns them in write order. `full_o`=1 and `push_ready_o`=0 once the 16th entry is stored. `empty_o` and `full_o` are never both high.
- R3: A write offered while the buffer is full (`push_ready_o`=0) is dropped and the stored entries stay unchanged.
- R4: With `fifo_en_i`=0 the depth is 1. One write sets `full_o`, and a second write before a read is dropped.
- R5: A read strobe while empty does not move the read pointer. `pop_data_o` shows the entry in the slot the pointer names, and `empty_o` stays 1.
- R6: `rx_irq_o` rises one cycle after a write that brings the count to the trigger level, which is 1. It falls one cycle after a read that leaves the count at trigger minus one (0), and a read while empty counts. A flush does not change it.
- R7: Any change of `fifo_en_i` flushes the buffer in that cycle: count and pointer become 0, `empty_o`=1 and `full_o`=0. A write or read in the same cycle is ignored.
- R8: Entry layout: bits 7:0 data, bit 8 framing, bit 9 parity, bit 10 break, bit 11 overrun. Each read loads entry bits 11:8 into `status_o`. A `status_clr_i` strobe zeroes it, and the clear wins over a read in the same cycle.
- R9: With `loop_en_i`=1 the receiver inputs are ignored and the loopback inputs are stored. `lb_brk_i` stores the entry 0x400 (break bit only, data 0).
- R10: A read and a write in the same cycle on a non-empty, non-full buffer both take effect. The read returns the older entry and the new entry stays behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: 16-deep buffer, 0: single holding register; a change flushes |
| loop_en_i | input | 1 | Select loopback source instead of receiver |
| rx_valid_i | input | 1 | Receiver has a character |
| rx_data_i | input | 8 | Receiver character |
| rx_err_i | input | 4 | Receiver conditions {overrun, break, parity, framing} |
| lb_valid_i | input | 1 | Loopback character strobe |
| lb_data_i | input | 8 | Loopback character |
| lb_brk_i | input | 1 | Loopback break strobe |
| push_ready_o | output | 1 | Buffer can accept a write |
| pop_i | input | 1 | Data-register read strobe |
| pop_data_o | output | 12 | Entry at the read pointer |
| status_clr_i | input | 1 | Clear receive status |
| status_o | output | 4 | Condition bits of the last entry read |
| empty_o | output | 1 | Empty flag |
| full_o | output | 1 | Full flag |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
The hardest case to reach is the read pointer resting on a slot whose old contents are known while the buffer is empty. Only then does a read while empty have a definite expected value. The stimulus gets there in two ways. One is filling and draining all 16 slots so that the pointer wraps back to slot 0. The other is flushing right after a holding-mode write, which leaves that character in slot 0. The flush case also leaves the interrupt high with an empty buffer, so the next read while empty shows that the interrupt is cleared by the count and not by the flush.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 4;
  localparam int ENTRY_W = DATA_W + ERR_W;
  // condition bit positions inside the error field
  localparam int ERR_FRM = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_BRK = 2;
  localparam int ERR_OVR = 3;

  typedef enum logic {MODE_HOLD = 1'b0, MODE_FIFO = 1'b1} depth_mode_e;

  function automatic logic [ENTRY_W-1:0] brk_entry();
    logic [ERR_W-1:0] e;
    e = '0;
    e[ERR_BRK] = 1'b1;
    return {e, {DATA_W{1'b0}}};
  endfunction
endpackage

// File: rtl/rxbuf_src_sel.sv
module rxbuf_src_sel
  import rxbuf_pkg::*;
(
  input  logic               loop_en_i,
  input  logic               rx_valid_i,
  input  logic [DATA_W-1:0]  rx_data_i,
  input  logic [ERR_W-1:0]   rx_err_i,
  input  logic               lb_valid_i,
  input  logic [DATA_W-1:0]  lb_data_i,
  input  logic               lb_brk_i,
  output logic               wr_valid_o,
  output logic [ENTRY_W-1:0] wr_entry_o
);
  always_comb begin
    if (loop_en_i) begin
      wr_valid_o = lb_valid_i | lb_brk_i;
      wr_entry_o = lb_brk_i ? brk_entry() : {{ERR_W{1'b0}}, lb_data_i};
    end else begin
      wr_valid_o = rx_valid_i;
      wr_entry_o = {rx_err_i, rx_data_i};
    end
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter  int ENTRY_W = 12,
  parameter  int DEPTH   = 16,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               flush_i,
  input  logic               wr_i,
  input  logic [ENTRY_W-1:0] wr_entry_i,
  input  logic               rd_i,
  output logic [ENTRY_W-1:0] rd_entry_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]   cnt_nxt_o,
  output logic               wr_ok_o,
  output logic               ready_o
);
  localparam logic [PTR_W-1:0] FULL_MASK = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]   rd_ptr_q, rd_ptr_d, mask, wr_idx;
  logic [CNT_W-1:0]   cnt_q, eff_depth;
  logic               rd_ok;
  logic [ENTRY_W-1:0] slot_w [DEPTH];

  assign mask      = fifo_en_i ? FULL_MASK : '0;
  assign eff_depth = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign ready_o   = (cnt_q != eff_depth);
  assign wr_idx    = (rd_ptr_q + cnt_q[PTR_W-1:0]) & mask;
  assign wr_ok_o   = wr_i & ready_o & ~flush_i;
  assign rd_ok     = rd_i & ~flush_i & (cnt_q != '0);

  always_comb begin
    if (flush_i) begin
      cnt_nxt_o = '0;
      rd_ptr_d  = '0;
    end else begin
      cnt_nxt_o = cnt_q + CNT_W'(wr_ok_o) - CNT_W'(rd_ok);
      rd_ptr_d  = rd_ok ? ((rd_ptr_q + PTR_W'(1)) & mask) : rd_ptr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      cnt_q    <= cnt_nxt_o;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENTRY_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q <= '0;
      else if (wr_ok_o && wr_idx == PTR_W'(g))      slot_q <= wr_entry_i;
    end
    assign slot_w[g] = slot_q;
  end

  assign rd_entry_o = slot_w[rd_ptr_q];
  assign cnt_o      = cnt_q;

  // R2: count never exceeds the physical depth
  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R3: a write while full with no read leaves the count alone
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && wr_i && !rd_i && !flush_i) |=> $stable(cnt_q));
  // R5: read while empty does not move the pointer
  p_empty_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && cnt_q == '0 && !flush_i) |=> $stable(rd_ptr_q));
  // R7: flush empties the buffer
  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && rd_ptr_q == '0));
endmodule

// File: rtl/rxbuf_flags.sv
module rxbuf_flags #(
  parameter int DEPTH    = 16,
  parameter int TRIG_LVL = 1,
  parameter int CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             flush_i,
  input  logic             wr_ok_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             empty_o,
  output logic             full_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] TRIG    = CNT_W'(TRIG_LVL);
  localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG_LVL - 1);

  logic [CNT_W-1:0] eff_depth;
  assign eff_depth = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      empty_o <= flush_i | (cnt_nxt_i == '0);
      full_o  <= ~flush_i & (cnt_nxt_i == eff_depth);
      // hysteresis: set on reaching trigger by a write, clear on dropping below by a read
      if (wr_ok_i && cnt_nxt_i == TRIG)                   irq_o <= 1'b1;
      else if (rd_i && !flush_i && cnt_nxt_i == TRIG_M1)  irq_o <= 1'b0;
    end
  end

  p_flag_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(wr_ok_i));
  p_irq_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(rd_i && !flush_i));
  p_flush_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && !full_o));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TRIG_LVL = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               loop_en_i,
  input  logic               rx_valid_i,
  input  logic [DATA_W-1:0]  rx_data_i,
  input  logic [ERR_W-1:0]   rx_err_i,
  input  logic               lb_valid_i,
  input  logic [DATA_W-1:0]  lb_data_i,
  input  logic               lb_brk_i,
  output logic               push_ready_o,
  input  logic               pop_i,
  output logic [ENTRY_W-1:0] pop_data_o,
  input  logic               status_clr_i,
  output logic [ERR_W-1:0]   status_o,
  output logic               empty_o,
  output logic               full_o,
  output logic               rx_irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  depth_mode_e        mode_q, mode_d;
  logic               flush;
  logic               wr_valid, wr_ok;
  logic [ENTRY_W-1:0] wr_entry;
  logic [CNT_W-1:0]   cnt, cnt_nxt;
  logic [ERR_W-1:0]   status_q;

  assign mode_d = fifo_en_i ? MODE_FIFO : MODE_HOLD;
  assign flush  = (mode_d != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_HOLD;
    else         mode_q <= mode_d;
  end

  rxbuf_src_sel u_src (
    .loop_en_i  (loop_en_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_err_i   (rx_err_i),
    .lb_valid_i (lb_valid_i),
    .lb_data_i  (lb_data_i),
    .lb_brk_i   (lb_brk_i),
    .wr_valid_o (wr_valid),
    .wr_entry_o (wr_entry)
  );

  rxbuf_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .flush_i    (flush),
    .wr_i       (wr_valid),
    .wr_entry_i (wr_entry),
    .rd_i       (pop_i),
    .rd_entry_o (pop_data_o),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .wr_ok_o    (wr_ok),
    .ready_o    (push_ready_o)
  );

  rxbuf_flags #(.DEPTH(DEPTH), .TRIG_LVL(TRIG_LVL), .CNT_W(CNT_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .flush_i   (flush),
    .wr_ok_i   (wr_ok),
    .rd_i      (pop_i),
    .cnt_nxt_i (cnt_nxt),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .irq_o     (rx_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  status_q <= '0;
    else if (status_clr_i)        status_q <= '0;
    else if (pop_i && !flush)     status_q <= pop_data_o[ENTRY_W-1:DATA_W];
  end
  assign status_o = status_q;

  p_status_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_clr_i |=> (status_o == '0));
  p_status_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush && !status_clr_i) |=> (status_o == $past(pop_data_o[ENTRY_W-1:DATA_W])));
  // R9: receiver activity alone cannot grow the buffer in loopback
  p_loop_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_en_i && !lb_valid_i && !lb_brk_i) |=> (cnt <= $past(cnt)));
endmodule

// File: tb/test_uart_rx_buffer.sv
`timescale 1ns/1ps
module test_uart_rx_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0, loop_en = 1'b0;
  logic        rx_valid = 1'b0, lb_valid = 1'b0, lb_brk = 1'b0;
  logic [7:0]  rx_data = '0, lb_data = '0;
  logic [3:0]  rx_err = '0;
  logic        pop = 1'b0, status_clr = 1'b0;
  logic        push_ready, empty, full, rx_irq;
  logic [11:0] pop_data;
  logic [3:0]  status;

  int checks = 0, errors = 0, m_depth = 1;
  bit done = 1'b0;
  logic [11:0] sb_q[$];
  logic [11:0] mon_empty_exp, last_popped;
  string       mon_req;
  event        mon_ev;

  always #4 clk = ~clk;

  uart_rx_buffer i_uart_rx_buffer (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .loop_en_i(loop_en),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err),
    .lb_valid_i(lb_valid), .lb_data_i(lb_data), .lb_brk_i(lb_brk),
    .push_ready_o(push_ready), .pop_i(pop), .pop_data_o(pop_data),
    .status_clr_i(status_clr), .status_o(status),
    .empty_o(empty), .full_o(full), .rx_irq_o(rx_irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard and compares the read data
  initial forever begin
    logic [11:0] exp;
    @(mon_ev);
    if (sb_q.size() > 0) exp = sb_q.pop_front();
    else                 exp = mon_empty_exp;
    last_popped = exp;
    chk(mon_req, "pop data", int'(pop_data), int'(exp));
  end

  task automatic push_rx(input logic [7:0] d, input logic [3:0] e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    if (!loop_en && sb_q.size() < m_depth) sb_q.push_back({e, d});
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic push_lb(input logic [7:0] d, input logic brk, input logic [7:0] rx_d);
    @(negedge clk);
    lb_valid = ~brk; lb_brk = brk; lb_data = d;
    rx_valid = 1'b1; rx_data = rx_d;
    if (sb_q.size() < m_depth) sb_q.push_back(brk ? 12'h400 : {4'h0, d});
    @(negedge clk);
    lb_valid = 1'b0; lb_brk = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic pop_op(input string req, input logic [11:0] empty_exp);
    @(negedge clk);
    pop = 1'b1;
    mon_req = req; mon_empty_exp = empty_exp;
    #1 -> mon_ev;
    @(negedge clk);
    pop = 1'b0;
    chk(req, "status after read", int'(status), int'(last_popped[11:8]));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "irq", rx_irq, 0);
    chk("R1", "status", status, 0);
    chk("R1", "ready", push_ready, 1);

    // R4 holding mode, R6 interrupt
    push_rx(8'h41, 4'h0);
    chk("R4", "full after one write", full, 1);
    chk("R4", "ready", push_ready, 0);
    chk("R6", "irq after write", rx_irq, 1);
    push_rx(8'h42, 4'h0);
    chk("R4", "full after dropped write", full, 1);
    pop_op("R4", 12'h000);
    chk("R6", "irq after draining read", rx_irq, 0);
    chk("R4", "empty", empty, 1);
    pop_op("R5", 12'h041);
    chk("R5", "empty stays", empty, 1);

    // R7 flush on mode change, R6 irq survives it
    push_rx(8'h55, 4'h0);
    chk("R6", "irq set", rx_irq, 1);
    @(negedge clk);
    fifo_en = 1'b1; rx_valid = 1'b1; rx_data = 8'h66;
    @(negedge clk);
    rx_valid = 1'b0;
    sb_q.delete(); m_depth = 16;
    chk("R7", "empty after flush", empty, 1);
    chk("R7", "full after flush", full, 0);
    chk("R7", "ready after flush", push_ready, 1);
    chk("R6", "irq kept over flush", rx_irq, 1);
    pop_op("R5 R7", 12'h055);
    chk("R6", "irq cleared by read while empty", rx_irq, 0);

    // R2 sixteen deep, R3 overflow drop, R8 status
    for (int i = 0; i < 16; i++)
      push_rx(8'hA0 + 8'(i), (i % 3 == 0) ? 4'(i) : 4'h0);
    chk("R2", "full at 16", full, 1);
    chk("R2", "ready at 16", push_ready, 0);
    push_rx(8'hEE, 4'h8);
    chk("R3", "full after dropped write", full, 1);
    for (int i = 0; i < 16; i++) pop_op("R2 R3 R8", 12'h000);
    chk("R8", "status of last entry", status, 4'hF);
    chk("R2", "empty after drain", empty, 1);
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    chk("R8", "status cleared", status, 0);
    pop_op("R5", 12'h0A0);

    // R9 loopback
    loop_en = 1'b1;
    push_lb(8'h22, 1'b0, 8'h11);
    push_lb(8'h00, 1'b1, 8'h12);
    pop_op("R9", 12'h000);
    pop_op("R9", 12'h000);
    chk("R9", "break status", status, 4'h4);
    push_rx(8'h33, 4'h0);
    chk("R9", "receiver ignored", empty, 1);

    // R10 simultaneous read and write
    loop_en = 1'b0;
    push_rx(8'h70, 4'h0);
    @(negedge clk);
    pop = 1'b1; rx_valid = 1'b1; rx_data = 8'h71; rx_err = 4'h0;
    mon_req = "R10"; mon_empty_exp = '0;
    #1 -> mon_ev;
    #1 sb_q.push_back(12'h071);
    @(negedge clk);
    pop = 1'b0; rx_valid = 1'b0;
    chk("R10", "not empty", empty, 0);
    chk("R10", "irq held", rx_irq, 1);
    pop_op("R10", 12'h000);
    chk("R10", "empty at end", empty, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule